// File: doc/BRIEF.md
# Buffered Byte-Wide Synchronous Serial Port

This block is a master-side serial port that moves one byte at a time over a clock line, a data output and a data input. It generates the shift clock from the system clock, sends bytes most-significant bit first when set to transmit, and collects bytes from the input pin when set to receive. Between the shifter and the processor there is a single byte of buffering. A ready flag reports the state of that buffer. Handshaking with it is done by one-cycle write and read strobes.

The port never overruns. In receive mode, suppose a byte finishes while the previous one is still waiting to be read. The shift clock then stops at its idle level, and the finished byte stays in the shift register. It is moved to the buffer as soon as software reads the buffer, and reception then carries on by itself. In transmit mode, a byte written during a transfer follows straight on. An empty buffer at the end of a byte lets the port go idle. Software chooses which clock edge launches data, and the input is sampled on the opposite edge. An optional one-cycle interrupt marks every transfer between the shift register and the buffer.

Top module: `ssi_port`

## Requirements
- R1: While `cfg_disable` is 1, the following hold:
  - `active` is 0 one cycle later.
  - `sck` sits at its idle level.
  - The buffer is emptied, so `ready` reads 1 in receive mode and 0 in transmit mode.
  - `tx_wr` has no effect.
  
  Clearing `cfg_disable` to 0 enables the port.
- R2: In transmit mode (`cfg_dir_tx`=1), a `tx_wr` to an idle port starts an 8-clock transfer. The byte appears on `sdo` bit 7 first and bit 0 last.
- R3: The clock edge that launches data is selected by `cfg_tx_fall`:
  - With `cfg_tx_fall`=0, data changes on rising edges of `sck`, and `sck` idles high.
  - With `cfg_tx_fall`=1, data changes on falling edges, and `sck` idles low.
  
  Input data is sampled on the opposite edge, which is also the first edge of each bit.
- R4: Each high or low phase of `sck` lasts `cfg_div`+1 system clock cycles.
- R5: In receive mode (`cfg_dir_tx`=0), enabling the port starts shift clocks at once (`active`=1 on the next cycle). Each byte is assembled from `sdi` bit 7 first. A completed byte is placed in `rx_data` with `ready`=0. Asserting `rx_rd` for one cycle releases the byte and sets `ready` back to 1.
- R6: In receive mode, suppose a byte completes while the buffer still holds an unread byte. The shift clock then stops at its idle level, and the new byte is kept. A later `rx_rd` moves it into the buffer and restarts reception, so no byte is lost or replaced.
- R7: `irq` is a one-cycle pulse after each transfer between the shift register and the buffer, and only when `cfg_irq_en`=1.
- R8: In transmit mode, if the buffer is empty when a byte finishes, `active` falls and `sck` returns to idle. `sdo` keeps the last bit sent (bit 0).
- R9: In transmit mode, `ready`=1 means the buffer holds a byte not yet sent. A byte written while another is shifting is sent straight after it without `active` dropping.
- R10: `active` stays 1 for the whole of a byte transfer and during a receive stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_disable | input | 1 | 1 holds the port inactive and flushes the buffer |
| cfg_dir_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_tx_fall | input | 1 | 1 = data launched on falling edge of sck |
| cfg_irq_en | input | 1 | Enables the transfer interrupt |
| cfg_div | input | DIV_W | Half-period of sck minus one, in clk cycles |
| tx_wr | input | 1 | One-cycle strobe writing tx_data into the buffer |
| tx_data | input | WIDTH | Byte to transmit |
| rx_rd | input | 1 | One-cycle strobe releasing the receive buffer |
| rx_data | output | WIDTH | Receive buffer contents |
| ready | output | 1 | Buffer status flag (meaning per direction, R5/R9) |
| active | output | 1 | Transfer or stall in progress |
| irq | output | 1 | One-cycle transfer interrupt |
| sck | output | 1 | Shift clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume three things about the inputs:
- `cfg_dir_tx`, `cfg_tx_fall` and `cfg_div` change only while `cfg_disable` is 1.
- `tx_wr` is issued only when the buffer is empty.
- `rx_rd` is issued only when a byte is waiting.

For example, the check that a stall always coincides with a full buffer depends on the direction not being switched mid-stall. The stimulus keeps to these limits as follows:
- All configuration changes are made inside disabled windows.
- The write and read tasks wait on `ready` before strobing.
- The external serial peer changes `sdi` only after a launch edge, well before the next sampling edge.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2
  } ssi_state_e;

  // Level the shift clock rests at: the first edge of a bit must be the
  // sampling edge, so a rising launch edge implies a high rest level.
  function automatic logic sck_rest_level(input logic launch_on_fall);
    return !launch_on_fall;
  endfunction

  // Width of the bit counter for a given word size.
  function automatic int bitcnt_width(input int word_w);
    return (word_w > 2) ? $clog2(word_w) : 1;
  endfunction

endpackage

// File: rtl/ssi_clkgen.sv
module ssi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             tick,
  input  logic             sdi,
  output logic [WIDTH-1:0] sh_data,
  output logic [WIDTH-1:0] done_data,
  output logic             sdo,
  output logic             phase,
  output logic             xmit_tick,
  output logic             byte_done
);

  localparam int CW = ssi_pkg::bitcnt_width(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] bitcnt;
  logic          samp;
  logic          samp_tick;

  assign samp_tick = tick && !phase;
  assign xmit_tick = tick && phase;
  assign byte_done = xmit_tick && (bitcnt == LAST);
  assign done_data = {sh_data[WIDTH-2:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data <= '0;
      sdo     <= 1'b0;
      phase   <= 1'b0;
      bitcnt  <= '0;
      samp    <= 1'b0;
    end else if (clear) begin
      phase  <= 1'b0;
      bitcnt <= '0;
    end else if (load) begin
      sh_data <= load_data;
      sdo     <= load_data[WIDTH-1];
      phase   <= 1'b0;
      bitcnt  <= '0;
    end else if (samp_tick) begin
      samp  <= sdi;
      phase <= 1'b1;
    end else if (xmit_tick) begin
      sh_data <= done_data;
      phase   <= 1'b0;
      bitcnt  <= byte_done ? '0 : bitcnt + 1'b1;
      if (!byte_done) sdo <= sh_data[WIDTH-2];
    end
  end

  // R8: outside launch edges and loads the output bit never moves
  assert_sdo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmit_tick && !load) |=> $stable(sdo));

endmodule

// File: rtl/ssi_port.sv
module ssi_port #(
  parameter int WIDTH = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_disable,
  input  logic             cfg_dir_tx,
  input  logic             cfg_tx_fall,
  input  logic             cfg_irq_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_data,
  output logic             ready,
  output logic             active,
  output logic             irq,
  output logic             sck,
  output logic             sdo,
  input  logic             sdi
);
  import ssi_pkg::*;

  ssi_state_e       state, state_nx;
  logic [WIDTH-1:0] buf_data;
  logic             buf_full;
  logic             en, run, tick, phase, xmit_tick, byte_done;
  logic [WIDTH-1:0] sh_data, done_data;
  logic             tx_load, rx_free, rx_xfer_run, rx_xfer_stall, xfer;

  assign en  = !cfg_disable;
  assign run = (state == ST_RUN);

  ssi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
  );

  ssi_shifter #(.WIDTH(WIDTH)) u_sh (
    .clk(clk), .rst_n(rst_n), .clear(cfg_disable), .load(tx_load),
    .load_data(buf_data), .tick(tick), .sdi(sdi), .sh_data(sh_data),
    .done_data(done_data), .sdo(sdo), .phase(phase),
    .xmit_tick(xmit_tick), .byte_done(byte_done)
  );

  // Buffer transfer events
  assign tx_load       = en && cfg_dir_tx && buf_full &&
                         ((state == ST_IDLE) || byte_done);
  assign rx_free       = !buf_full || rx_rd;
  assign rx_xfer_run   = en && !cfg_dir_tx && byte_done && rx_free;
  assign rx_xfer_stall = en && !cfg_dir_tx && (state == ST_STALL) && rx_free;
  assign xfer          = tx_load || rx_xfer_run || rx_xfer_stall;

  always_comb begin
    state_nx = state;
    if (!en) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (!cfg_dir_tx || buf_full) state_nx = ST_RUN;
        ST_RUN:   if (byte_done) begin
                    if (cfg_dir_tx) state_nx = buf_full ? ST_RUN : ST_IDLE;
                    else            state_nx = rx_free  ? ST_RUN : ST_STALL;
                  end
        ST_STALL: if (cfg_dir_tx)   state_nx = ST_IDLE;
                  else if (rx_free) state_nx = ST_RUN;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      buf_data <= '0;
      buf_full <= 1'b0;
      irq      <= 1'b0;
    end else begin
      state <= state_nx;
      irq   <= xfer && cfg_irq_en;
      if (!en) begin
        buf_full <= 1'b0;
      end else if (cfg_dir_tx) begin
        if (tx_wr) begin
          buf_data <= tx_data;
          buf_full <= 1'b1;
        end else if (tx_load) begin
          buf_full <= 1'b0;
        end
      end else begin
        if (rx_xfer_run) begin
          buf_data <= done_data;
          buf_full <= 1'b1;
        end else if (rx_xfer_stall) begin
          buf_data <= sh_data;
          buf_full <= 1'b1;
        end else if (rx_rd) begin
          buf_full <= 1'b0;
        end
      end
    end
  end

  assign rx_data = buf_data;
  assign ready   = cfg_dir_tx ? buf_full : !buf_full;
  assign active  = (state != ST_IDLE);
  assign sck     = sck_rest_level(cfg_tx_fall) ^ phase;

  // R1: disable forces the port inactive
  assert_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> !active);

  // R3: outside a running transfer the clock rests at its idle level
  assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> (sck == sck_rest_level(cfg_tx_fall)));

  // R6: a held byte does not change while stalled
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STALL) && $past(state == ST_STALL)) |-> $stable(sh_data));

  // R6: a stall only exists while the receive buffer is occupied
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STALL) && !cfg_dir_tx) |-> buf_full);

  // R7: the interrupt is a single-cycle pulse
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: a write to an enabled transmit port marks the buffer ready
  assert_tx_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && cfg_dir_tx && en) |=> ready);

endmodule

// File: tb/sim_ssi_port.sv
module sim_ssi_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_disable = 1'b1, cfg_dir_tx = 1'b0, cfg_tx_fall = 1'b0;
  logic       cfg_irq_en = 1'b1;
  logic [7:0] cfg_div = 8'd2;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, sdi = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       ready, active, irq, sck, sdo;

  always #2 clk = ~clk;

  ssi_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_dir_tx(cfg_dir_tx),
    .cfg_tx_fall(cfg_tx_fall), .cfg_irq_en(cfg_irq_en), .cfg_div(cfg_div),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .ready(ready), .active(active), .irq(irq), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];
  logic [7:0] rx_stim[$];
  int irq_cnt = 0, act_falls = 0, edge_cnt = 0, cyc = 0;
  logic [7:0] mon_sh = 0, slv_byte = 0;
  int mon_nb = 0, slv_idx = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic idle_lvl();
    return cfg_tx_fall ? 1'b0 : 1'b1;   // R3 rest level
  endfunction

  // Monitor: sck edges, serial scoreboard, irq and activity counts
  initial begin
    logic prev_sck, prev_act;
    int last_edge;
    prev_sck = 1'b1; prev_act = 1'b0; last_edge = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (irq) irq_cnt++;
      if (prev_act && !active) act_falls++;
      if (prev_act && sck != prev_sck) begin
        edge_cnt++;
        if (sck != idle_lvl()) begin
          if (cfg_dir_tx) begin
            mon_sh = {mon_sh[6:0], sdo};
            mon_nb++;
            if (mon_nb == 8) begin
              mon_nb = 0;
              if (tx_exp.size() == 0) check("R2 unexpected byte", mon_sh, 0);
              else check("R2 serial byte", mon_sh, tx_exp.pop_front());
            end
          end
        end else begin
          check("R4 half period", cyc - last_edge, int'(cfg_div) + 1);
          if (!cfg_dir_tx) begin
            slv_idx++;
            if (slv_idx == 8) begin
              slv_idx = 0;
              slv_byte = (rx_stim.size() != 0) ? rx_stim.pop_front() : 8'h00;
            end
            sdi = slv_byte[7 - slv_idx];
          end
        end
        last_edge = cyc;
      end
      prev_sck = sck;
      prev_act = active;
    end
  end

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    while (ready) @(negedge clk);
    tx_wr = 1'b1; tx_data = b; tx_exp.push_back(b);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk);
    while (ready) @(negedge clk);
    if (rx_exp.size() == 0) check("R5 unexpected byte", rx_data, 0);
    else check("R5 received byte", rx_data, rx_exp.pop_front());
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_tx_done();
    int guard = 0;
    @(negedge clk);
    while ((tx_exp.size() != 0 || active) && guard < 5000) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic go_disabled();
    @(negedge clk);
    cfg_disable = 1'b1;
    repeat (3) @(negedge clk);
    mon_nb = 0;
  endtask

  task automatic start_rx(input logic [7:0] b0);
    slv_byte = b0; slv_idx = 0; sdi = b0[7];
    @(negedge clk);
    cfg_disable = 1'b0;
    @(negedge clk);
    check("R5 active right after enable", active, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int irq0, edges0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // Reset state (R1)
    check("R1 reset active", active, 0);
    check("R1 reset sck idle", sck, 1);
    check("R1 reset irq", irq, 0);
    check("R1 reset ready rx-empty", ready, 1);

    // Transmit, launch on rising edge
    cfg_dir_tx = 1'b1;
    @(negedge clk);
    tx_wr = 1'b1; tx_data = 8'h77;             // R1: ignored while disabled
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 write ignored active", active, 0);
    check("R1 write ignored ready", ready, 0);
    cfg_disable = 1'b0;
    irq_cnt = 0; act_falls = 0;
    send_tx(8'h35);
    send_tx(8'hCA);
    check("R9 ready while byte pending", ready, 1);
    send_tx(8'h0F);
    wait_tx_done();
    check("R9 no gap between bytes", act_falls, 1);
    check("R7 irq per transfer", irq_cnt, 3);
    check("R8 sdo holds last bit", sdo, 1);
    check("R8 sck at rest", sck, 1);
    repeat (30) @(negedge clk);
    check("R8 sdo still held", sdo, 1);
    check("R8 active low", active, 0);

    // Transmit, launch on falling edge
    go_disabled();
    check("R1 disabled inactive", active, 0);
    cfg_tx_fall = 1'b1;
    @(negedge clk);
    check("R3 rest low for falling launch", sck, 0);
    cfg_disable = 1'b0;
    send_tx(8'hA5);
    send_tx(8'h00);
    send_tx(8'hFF);
    send_tx(8'h80);
    wait_tx_done();
    check("R8 sdo holds bit0 of 80", sdo, 0);
    check("R3 sck rest after tx", sck, 0);

    // Interrupt disabled
    cfg_irq_en = 1'b0;
    irq0 = irq_cnt;
    send_tx(8'h3C);
    wait_tx_done();
    check("R7 irq gated off", irq_cnt - irq0, 0);

    // Receive, launch on rising edge, with stall
    go_disabled();
    cfg_dir_tx = 1'b0; cfg_tx_fall = 1'b0; cfg_irq_en = 1'b1;
    @(negedge clk);
    check("R1 rx ready after flush", ready, 1);
    irq_cnt = 0;
    rx_stim = '{8'h96, 8'hE1, 8'h5A};
    rx_exp  = '{8'h35, 8'h96, 8'hE1, 8'h5A};
    start_rx(8'h35);
    read_rx();
    repeat (300) @(negedge clk);
    edges0 = edge_cnt;
    repeat (60) @(negedge clk);
    check("R6 clock frozen in stall", edge_cnt - edges0, 0);
    check("R6 sck at rest in stall", sck, 1);
    check("R10 active during stall", active, 1);
    check("R6 buffer still full", ready, 0);
    check("R7 irq count at stall", irq_cnt, 2);
    read_rx();
    read_rx();
    read_rx();

    // Receive, launch on falling edge, fastest clock
    go_disabled();
    cfg_tx_fall = 1'b1; cfg_div = 8'd0;
    rx_stim = '{8'hC3, 8'h01};
    rx_exp  = '{8'h6E, 8'hC3, 8'h01};
    start_rx(8'h6E);
    read_rx();
    read_rx();
    read_rx();
    go_disabled();
    check("R1 inactive after disable", active, 0);
    check("R3 rest low after rx", sck, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule